// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous memory core and decides, on every rising clock edge, which word address the core works on. A fresh external address is taken in when either of two active-low load strobes is asserted. One strobe serves a processor and always opens a read. The other serves a memory controller and opens a read or a write, depending on the write-control inputs.

After a load, the block walks the two least significant address bits through a four-beat burst. Each clock with the active-low advance input low steps one beat. A clock with advance high is a wait cycle and holds the address. A static mode pin picks the order of the beats. With mode low the low bits count up from the loaded value and wrap. With mode high the loaded low bits are XORed with the beat number. The burst keeps cycling through the same four words until the next load.

Three chip enables gate every load. Two are active low and one is active high. A load strobe seen while the enables are not all asserted deselects the block. The block then stays idle until the next valid load. Outputs are the full current address, a one-cycle pulse that marks the first beat of a new access, a write flag and an active flag.

Top module: `burst_addr_seq`

## Requirements
- R1: A qualified, selected load registers `addr_in` at the clock edge. In the following cycle `cur_addr` equals that address and `start_pulse` is high. `start_pulse` is low in every other cycle.
- R2: While active and with no strobe, `adv_n` low advances the burst by one beat at the edge. `adv_n` high leaves `cur_addr` unchanged (wait cycle).
- R3: With `mode_ilv` = 0 the two low address bits equal (loaded low bits + beat) modulo 4. The upper bits keep their loaded value.
- R4: `ads_proc_n` low acts only when `ce1_n` is also low. A selected processor load always gives `is_write` = 0. With `ce1_n` high the processor strobe is ignored.
- R5: A selected controller load gives `is_write` = 1 when `wr_all_n` is low. It also gives `is_write` = 1 when `wr_gate_n` is low and at least one bit of `wr_lane_n` is low. Otherwise it gives `is_write` = 0.
- R6: When both strobes are low and `ce1_n` is low, the processor strobe wins and the access is a read.
- R7: Chip select means `ce1_n`=0, `ce2_n`=0 and `ce3`=1 together. A strobe that acts while select is absent clears `active` and `is_write` and keeps the address. While idle, `adv_n` does not move `cur_addr`.
- R8: With `mode_ilv` = 1 the two low address bits equal (loaded low bits XOR beat), for beats 0, 1, 2 and 3.
- R9: After the fourth beat the burst returns to the loaded address and keeps cycling while `adv_n` stays low.
- R10: While `rst_n` is low the block is idle: `active`, `start_pulse` and `is_write` are 0 and `cur_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address |
| ads_proc_n | input | 1 | Processor load strobe, active low |
| ads_ctrl_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce3 | input | 1 | Third chip enable, active high |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Full-width write request, active low |
| wr_gate_n | input | 1 | Byte-lane write gate, active low |
| wr_lane_n | input | LANES | Per-lane write requests, active low |
| cur_addr | output | ADDR_W | Current internal address |
| start_pulse | output | 1 | First beat of a new access |
| is_write | output | 1 | Current access is a write |
| active | output | 1 | Block is selected |

## Verification
Two pairs of functions can meet in the same clock. The first pair is the two load strobes: both are driven low with all enables asserted and a write requested, and the bench judges the result by a read flag and the processor's address. The second pair is a controller strobe together with a missing enable: here the deselect must win over the load, which the bench sees as `active` dropping while `cur_addr` keeps the old address. Advance pulses sent while idle then show that the deselected state does not step the burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // action chosen for the coming clock edge
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } seq_cmd_e;

endpackage

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
    import burst_seq_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2_n,
    input  logic             ce3,
    input  logic             wr_all_n,
    input  logic             wr_gate_n,
    input  logic [LANES-1:0] wr_lane_n,
    input  logic             active_q,
    output seq_cmd_e         cmd,
    output logic             load_write
);
    logic proc_hit;
    logic ctrl_hit;
    logic selected;
    logic wr_req;

    always_comb begin
        proc_hit   = !ads_proc_n && !ce1_n;
        ctrl_hit   = !ads_ctrl_n && !proc_hit;
        selected   = !ce1_n && !ce2_n && ce3;
        wr_req     = !wr_all_n || (!wr_gate_n && (wr_lane_n != {LANES{1'b1}}));
        load_write = ctrl_hit && wr_req;
        if (proc_hit || ctrl_hit) begin
            cmd = selected ? CMD_LOAD : CMD_DESEL;
        end else if (active_q && !adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_lo,
    input  logic [LOW_W-1:0] beat,
    input  logic             mode_ilv,
    output logic [LOW_W-1:0] low_addr
);
    logic [LOW_W-1:0] lin_lo;
    logic [LOW_W-1:0] ilv_lo;

    genvar b;
    generate
        for (b = 0; b < LOW_W; b++) begin : g_ilv
            assign ilv_lo[b] = start_lo[b] ^ beat[b];
        end
    endgenerate

    assign lin_lo   = start_lo + beat;
    assign low_addr = mode_ilv ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int LANES     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              ce3,
    input  logic              mode_ilv,
    input  logic              wr_all_n,
    input  logic              wr_gate_n,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              start_pulse,
    output logic              is_write,
    output logic              active
);
    localparam int LOW_W = $clog2(BURST_LEN);
    localparam int HI_W  = ADDR_W - LOW_W;

    typedef struct packed {
        logic [HI_W-1:0]  base_hi;
        logic [LOW_W-1:0] start_lo;
        logic [LOW_W-1:0] beat;
        logic             active;
        logic             start;
        logic             write;
    } seq_state_t;

    seq_state_t st_d, st_q;
    seq_cmd_e   cmd;
    logic       load_write;
    logic [LOW_W-1:0] low_addr;

    burst_seq_decode #(.LANES(LANES)) u_dec (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .ce1_n      (ce1_n),
        .ce2_n      (ce2_n),
        .ce3        (ce3),
        .wr_all_n   (wr_all_n),
        .wr_gate_n  (wr_gate_n),
        .wr_lane_n  (wr_lane_n),
        .active_q   (st_q.active),
        .cmd        (cmd),
        .load_write (load_write)
    );

    burst_seq_order #(.LOW_W(LOW_W)) u_ord (
        .start_lo (st_q.start_lo),
        .beat     (st_q.beat),
        .mode_ilv (mode_ilv),
        .low_addr (low_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.base_hi  = addr_in[ADDR_W-1:LOW_W];
                st_d.start_lo = addr_in[LOW_W-1:0];
                st_d.beat     = '0;
                st_d.active   = 1'b1;
                st_d.start    = 1'b1;
                st_d.write    = load_write;
            end
            CMD_DESEL: begin
                st_d.active = 1'b0;
                st_d.write  = 1'b0;
            end
            CMD_STEP: begin
                st_d.beat = st_q.beat + 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr    = {st_q.base_hi, low_addr};
    assign start_pulse = st_q.start;
    assign is_write    = st_q.write;
    assign active      = st_q.active;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ads_proc_n,
    input logic              ads_ctrl_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              ce3,
    input logic              mode_ilv,
    input logic              wr_all_n,
    input logic              wr_gate_n,
    input logic [LANES-1:0]  wr_lane_n,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              start_pulse,
    input logic              is_write,
    input logic              active
);
    logic sel_ok;
    assign sel_ok = !ce1_n && !ce2_n && ce3;

    // R1: a selected processor load shows its address next cycle
    p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && sel_ok) |=> (start_pulse && cur_addr == $past(addr_in)));

    // R4 / R6: a processor load is always a read
    p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && sel_ok) |=> !is_write);

    // R2: a wait cycle keeps the address
    p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && ads_proc_n && ads_ctrl_n) |=> $stable(cur_addr));

    // R7: a controller strobe without select leaves the block idle
    p_deselect_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_ctrl_n && ads_proc_n && !sel_ok) |=> (!active && !is_write && !start_pulse));

    // R1: a start pulse never lasts two cycles without a new strobe
    p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && ads_proc_n && ads_ctrl_n) |=> !start_pulse);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          ce1_n = 1'b0, ce2_n = 1'b0, ce3 = 1'b1, mode_ilv = 1'b0;
    logic          wr_all_n = 1'b1, wr_gate_n = 1'b1;
    logic [1:0]    wr_lane_n = 2'b11;
    logic [AW-1:0] cur_addr;
    logic          start_pulse, is_write, active;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3), .mode_ilv(mode_ilv),
        .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n), .wr_lane_n(wr_lane_n),
        .cur_addr(cur_addr), .start_pulse(start_pulse),
        .is_write(is_write), .active(active)
    );

    typedef struct packed {
        logic          ap;
        logic          ac;
        logic          adv;
        logic          c1;
        logic          c2;
        logic          c3;
        logic          md;
        logic [3:0]    wr;   // {wr_all_n, wr_gate_n, wr_lane_n[1:0]}
        logic [AW-1:0] a;
        logic [AW-1:0] ea;
        logic          es;
        logic          ew;
        logic          eact;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{0,1,1,0,0,1,0,4'hF,18'h00011,18'h00011,1,0,1,4'd1},  // R1 processor load
        '{1,1,0,0,0,1,0,4'hF,18'h0,    18'h00012,0,0,1,4'd3},  // R3 linear step
        '{1,1,0,0,0,1,0,4'hF,18'h0,    18'h00013,0,0,1,4'd3},  // R3
        '{1,1,0,0,0,1,0,4'hF,18'h0,    18'h00010,0,0,1,4'd9},  // R9 wrap low bits
        '{1,1,0,0,0,1,0,4'hF,18'h0,    18'h00011,0,0,1,4'd9},  // R9 back to start
        '{1,1,1,0,0,1,0,4'hF,18'h0,    18'h00011,0,0,1,4'd2},  // R2 wait
        '{1,0,1,0,0,1,1,4'h7,18'h00102,18'h00102,1,1,1,4'd5},  // R5 full write
        '{1,1,0,0,0,1,1,4'hF,18'h0,    18'h00103,0,1,1,4'd8},  // R8 interleaved beat 1
        '{1,1,0,0,0,1,1,4'hF,18'h0,    18'h00100,0,1,1,4'd8},  // R8 beat 2
        '{1,1,0,0,0,1,1,4'hF,18'h0,    18'h00101,0,1,1,4'd8},  // R8 beat 3
        '{0,0,1,0,0,1,1,4'h7,18'h00203,18'h00203,1,0,1,4'd6},  // R6 both strobes
        '{1,0,1,0,0,0,1,4'hF,18'h3FFFF,18'h00203,0,0,0,4'd7},  // R7 deselect
        '{1,1,0,0,0,1,1,4'hF,18'h0,    18'h00203,0,0,0,4'd7},  // R7 idle no step
        '{0,1,1,1,0,1,1,4'hF,18'h01111,18'h00203,0,0,0,4'd4},  // R4 unqualified strobe
        '{1,0,1,0,0,1,0,4'hA,18'h00300,18'h00300,1,1,1,4'd5},  // R5 lane write
        '{1,0,1,0,0,1,0,4'hB,18'h00301,18'h00301,1,0,1,4'd5}   // R5 gate without lane
    };

    task automatic check(input string tag, input logic [AW-1:0] ea,
                         input logic es, input logic ew, input logic eact);
        n_chk++;
        if (cur_addr !== ea || start_pulse !== es || is_write !== ew || active !== eact) begin
            n_bad++;
            $display("FAIL %s: got addr=%h start=%b wr=%b act=%b, expected addr=%h start=%b wr=%b act=%b",
                     tag, cur_addr, start_pulse, is_write, active, ea, es, ew, eact);
        end
    endtask

    task automatic idle_inputs();
        ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
        ce1_n = 1'b0; ce2_n = 1'b0; ce3 = 1'b1;
        wr_all_n = 1'b1; wr_gate_n = 1'b1; wr_lane_n = 2'b11;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R10 reset", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ads_proc_n = TBL[i].ap; ads_ctrl_n = TBL[i].ac; adv_n = TBL[i].adv;
            ce1_n = TBL[i].c1; ce2_n = TBL[i].c2; ce3 = TBL[i].c3;
            mode_ilv = TBL[i].md;
            {wr_all_n, wr_gate_n, wr_lane_n} = TBL[i].wr;
            addr_in = TBL[i].a;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[i].rq, i),
                  TBL[i].ea, TBL[i].es, TBL[i].ew, TBL[i].eact);
        end

        // R7: processor strobe with second enable off deselects
        idle_inputs();
        ads_proc_n = 1'b0; ce2_n = 1'b1; addr_in = 18'h00400;
        @(negedge clk);
        check("R7 proc deselect", 18'h00301, 1'b0, 1'b0, 1'b0);

        // R9: linear burst from low bits 3 wraps to 0 and back to 3
        idle_inputs(); mode_ilv = 1'b0;
        ads_ctrl_n = 1'b0; addr_in = 18'h00507;
        @(negedge clk);
        check("R9 load 507", 18'h00507, 1'b1, 1'b0, 1'b1);
        idle_inputs(); adv_n = 1'b0;
        @(negedge clk);
        check("R9 wrap to 504", 18'h00504, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 return 507", 18'h00507, 1'b0, 1'b0, 1'b1);

        // R10: reset in the middle of a burst
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1; idle_inputs();
        @(negedge clk);
        check("R10 after reset idle", '0, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule